// File: doc/BRIEF.md
# Interrupt mask and status controller

This block is the interrupt register set of a network controller that has up to thirty event sources. Each source sends a one-cycle pulse. The pulse is latched into a pending status register. A per-source mask decides whether a pending bit may drive the single interrupt line. Software does not write the mask word directly. It clears mask bits by writing ones to an enable address and sets mask bits by writing ones to a disable address. The mask word is read back at its own address, where a 1 means the source is disabled.

The mask address cannot change the mask. A write there is steered into the status register instead, and it loads the pending bits whether or not they are masked. Driver code can use this to raise any interrupt on demand and so exercise its handlers. Reading the status register returns the pending bits and clears them. The interrupt output is a registered OR of the pending bits that are not masked.

Access uses a plain synchronous strobe interface. Read data appears on the cycle after the read strobe. Only source positions 0 to 7, 10 to 15 and 18 to 29 exist. The remaining positions are inert.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask reads 0x03FFFFFF, the status reads 0 and the interrupt output is low.
- R2: A write to offset 0x028 clears every mask bit whose data bit is 1 and leaves every mask bit whose data bit is 0 unchanged.
- R3: A write to offset 0x02C sets every mask bit whose data bit is 1 and leaves every mask bit whose data bit is 0 unchanged.
- R4: A read of offset 0x030 returns the mask word, with 1 for a disabled source and 0 for an enabled one, on the cycle after the read strobe.
- R5: A write to offset 0x030 leaves the mask unchanged and loads the implemented status bits from the write data, setting the bits written as 1 and clearing the bits written as 0, whatever the mask holds.
- R6: An event pulse on an implemented position sets that status bit. When an event pulse and a status clear or load fall in the same cycle, the event bit ends up set.
- R7: A read of offset 0x024 returns the status word on the next cycle and clears every status bit, including the seconds-increment bit at position 26.
- R8: The interrupt output goes high one cycle after any status bit is 1 while its mask bit is 0, and stays low while every pending bit is masked.
- R9: Positions 8, 9, 16, 17, 30 and 31 always read 0 in the status word, ignore events and writes, and keep their reset value in the mask (1 at 8, 9, 16, 17 and 0 at 30, 31).
- R10: A read of offset 0x028, offset 0x02C or any unmapped offset returns 0 and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe, 0 otherwise |
| event_pulse | input | 32 | One-cycle event pulses, one per source position |
| irq | output | 1 | Registered interrupt request |

## Verification
Several rules are checked by assertions on every cycle. An enable write must leave the chosen mask bits clear, and a disable write must leave them set. A write to the mask address must leave the mask unchanged. Every event pulse must appear in the status word on the next cycle, and the inert positions must stay zero in the status word. A rise of the interrupt must follow a pending unmasked bit. The bench scenarios show what a single-cycle property cannot. These include the reset values as seen on the bus, the clear-on-read of every position including bit 26, and test loads that clear bits as well as set them. The bench also shows an event beating a clear in the same cycle, the interrupt staying low under a full mask, and reads of other offsets having no side effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // implemented source positions: 0-7, 10-15, 18-29
    localparam word_t SRC_VALID = 32'h3FFC_FCFF;
    localparam word_t MASK_INIT = 32'h03FF_FFFF;

    localparam addr_t OFS_STATUS  = 8'h24;
    localparam addr_t OFS_ENABLE  = 8'h28;
    localparam addr_t OFS_DISABLE = 8'h2C;
    localparam addr_t OFS_MASK    = 8'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_DISABLE,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        logic mask_clr;    // enable write
        logic mask_set;    // disable write
        logic stat_load;   // test load through the mask address
        logic stat_rd;     // status read, clears
        logic mask_rd;     // mask read
    } access_t;

    function automatic reg_sel_e decode_offset(input addr_t a);
        case (a)
            OFS_STATUS:  return SEL_STATUS;
            OFS_ENABLE:  return SEL_ENABLE;
            OFS_DISABLE: return SEL_DISABLE;
            OFS_MASK:    return SEL_MASK;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic    wr_en,
    input  logic    rd_en,
    input  addr_t   addr,
    output access_t acc
);

    reg_sel_e sel;

    always_comb begin
        sel           = decode_offset(addr);
        acc           = '0;
        acc.mask_clr  = wr_en && (sel == SEL_ENABLE);
        acc.mask_set  = wr_en && (sel == SEL_DISABLE);
        acc.stat_load = wr_en && (sel == SEL_MASK);
        acc.stat_rd   = rd_en && (sel == SEL_STATUS);
        acc.mask_rd   = rd_en && (sel == SEL_MASK);
    end

endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
    import irqc_pkg::*;
#(
    parameter word_t VALID_BITS = SRC_VALID,
    parameter word_t RESET_VAL  = MASK_INIT
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_en,
    input  logic  set_en,
    input  logic  load_en,
    input  word_t wdata,
    output word_t mask_q
);

    word_t sel_bits;

    always_comb sel_bits = wdata & VALID_BITS;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= RESET_VAL;
        else if (clr_en)
            mask_q <= mask_q & ~sel_bits;
        else if (set_en)
            mask_q <= mask_q | sel_bits;
    end

    // R2
    enable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((mask_q & $past(sel_bits)) == '0));

    // R3
    disable_sets_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((mask_q & $past(sel_bits)) == $past(sel_bits)));

    // R5
    mask_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
#(
    parameter word_t VALID_BITS = SRC_VALID
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  logic  rd_clr,
    input  word_t wdata,
    input  word_t events,
    output word_t stat_q
);

    word_t base;
    word_t stat_d;

    always_comb begin
        base = stat_q;
        if (load_en) base = wdata;
        if (rd_clr)  base = '0;
        stat_d = (base | events) & VALID_BITS;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    // R6
    event_latched_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(events & VALID_BITS)) == $past(events & VALID_BITS)));

    // R9
    inert_status_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~VALID_BITS) == '0));

endmodule

// File: rtl/irqc_irq.sv
module irqc_irq
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t stat,
    input  word_t mask,
    output logic  irq_q
);

    logic live;

    always_comb live = |(stat & ~mask);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= live;
    end

    // R8
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(stat & ~mask) != '0));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irqc_pkg::*;
#(
    parameter word_t VALID_BITS = SRC_VALID,
    parameter word_t MASK_RESET = MASK_INIT
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] event_pulse,
    output logic              irq
);

    access_t acc;
    word_t   mask_w;
    word_t   stat_w;

    irqc_decode u_decode (
        .wr_en (bus_wr),
        .rd_en (bus_rd),
        .addr  (bus_addr),
        .acc   (acc)
    );

    irqc_mask #(
        .VALID_BITS (VALID_BITS),
        .RESET_VAL  (MASK_RESET)
    ) u_mask (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (acc.mask_clr),
        .set_en  (acc.mask_set),
        .load_en (acc.stat_load),
        .wdata   (bus_wdata),
        .mask_q  (mask_w)
    );

    irqc_status #(
        .VALID_BITS (VALID_BITS)
    ) u_status (
        .clk     (clk),
        .rst     (rst),
        .load_en (acc.stat_load),
        .rd_clr  (acc.stat_rd),
        .wdata   (bus_wdata),
        .events  (event_pulse),
        .stat_q  (stat_w)
    );

    irqc_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat_w),
        .mask  (mask_w),
        .irq_q (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (acc.stat_rd)
            bus_rdata <= stat_w;
        else if (acc.mask_rd)
            bus_rdata <= mask_w;
        else
            bus_rdata <= '0;
    end

    // R7
    status_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.stat_rd && event_pulse == '0) |=> (stat_w == '0));

endmodule

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;

    localparam logic [31:0] VALID = 32'h3FFC_FCFF;
    localparam logic [31:0] MRST  = 32'h03FF_FFFF;
    localparam logic [7:0]  A_ST  = 8'h24;
    localparam logic [7:0]  A_EN  = 8'h28;
    localparam logic [7:0]  A_DIS = 8'h2C;
    localparam logic [7:0]  A_MSK = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] event_pulse = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] m_mask;
    logic [31:0] rv;

    always #10 clk = ~clk;

    irq_mask_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .event_pulse (event_pulse),
        .irq         (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        event_pulse = v;
        @(negedge clk);
        event_pulse = '0;
    endtask

    task automatic wait_irq(input string req, input logic exp);
        @(negedge clk);
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_mask = MRST;

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(A_MSK, rv); check("R1 R4 mask after reset", rv, MRST);
        rd(A_ST, rv);  check("R1 status after reset", rv, 32'h0);

        // R6 R7 R8 R9: event on each position
        for (int b = 0; b < 32; b++) begin
            logic [31:0] bit_v;
            bit_v = 32'h1 << b;
            pulse(bit_v);
            wait_irq("R8 irq after event", ((bit_v & VALID & ~m_mask) != 0));
            rd(A_ST, rv);
            check((b == 26) ? "R6 R7 R9 seconds bit latched" : "R6 R9 event latched", rv, bit_v & VALID);
            rd(A_ST, rv);
            check("R7 cleared by read", rv, 32'h0);
            wait_irq("R8 irq drops after clear", 1'b0);
        end

        // R2 R9 enable sweep
        for (int b = 0; b < 32; b++) begin
            wr(A_EN, 32'h1 << b);
            m_mask = m_mask & ~((32'h1 << b) & VALID);
            rd(A_MSK, rv); check("R2 R9 enable bit", rv, m_mask);
        end
        // R3 R9 disable sweep
        for (int b = 0; b < 32; b++) begin
            wr(A_DIS, 32'h1 << b);
            m_mask = m_mask | ((32'h1 << b) & VALID);
            rd(A_MSK, rv); check("R3 R9 disable bit", rv, m_mask);
        end
        // R2 R3 zeros leave bits unchanged
        wr(A_EN, 32'h0000_00F0);
        m_mask = m_mask & ~32'h0000_00F0;
        wr(A_DIS, 32'h0000_0030);
        m_mask = m_mask | 32'h0000_0030;
        rd(A_MSK, rv); check("R2 R3 mixed pattern", rv, m_mask);

        // R8 fully masked pending bit keeps irq low
        wr(A_DIS, 32'hFFFF_FFFF);
        m_mask = m_mask | VALID;
        pulse(32'h0000_0001);
        wait_irq("R8 masked pending keeps irq low", 1'b0);
        wr(A_EN, 32'h0000_0001);
        m_mask = m_mask & ~32'h1;
        wait_irq("R8 irq after unmask", 1'b1);
        rd(A_ST, rv); check("R7 status read", rv, 32'h1);

        // R5 test load: mask unchanged, status loaded regardless of mask
        wr(A_MSK, 32'hFFFF_FFFF);
        rd(A_MSK, rv); check("R5 mask unchanged by write", rv, m_mask);
        rd(A_ST, rv);  check("R5 R9 forced status", rv, VALID);
        wr(A_MSK, 32'h0000_00F0);
        wr(A_MSK, 32'h0000_0030);
        rd(A_ST, rv);  check("R5 load clears bits", rv, 32'h0000_0030);

        // R5 R8 forced bits raise irq once enabled
        wr(A_EN, 32'hFFFF_FFFF);
        m_mask = m_mask & ~VALID;
        rd(A_MSK, rv); check("R2 all enabled", rv, MRST & ~VALID);
        for (int b = 0; b < 32; b++) begin
            logic [31:0] bit_v;
            bit_v = 32'h1 << b;
            wr(A_MSK, bit_v);
            wait_irq("R5 R8 irq from forced bit", ((bit_v & VALID) != 0));
            rd(A_ST, rv); check("R5 R9 forced bit read", rv, bit_v & VALID);
            wait_irq("R8 irq low after read", 1'b0);
        end

        // R6 event beats read clear in same cycle
        wr(A_MSK, 32'h0000_0003);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_ST; event_pulse = 32'h0000_0001;
        @(negedge clk);
        bus_rd = 1'b0; event_pulse = '0;
        check("R7 read returns old status", bus_rdata, 32'h0000_0003);
        rd(A_ST, rv); check("R6 event wins over clear", rv, 32'h0000_0001);

        // R6 event beats test load in same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_MSK; bus_wdata = 32'h0000_0000; event_pulse = 32'h0000_0400;
        @(negedge clk);
        bus_wr = 1'b0; event_pulse = '0;
        rd(A_ST, rv); check("R6 event wins over load", rv, 32'h0000_0400);

        // R10 other reads return 0, no side effect
        pulse(32'h0000_0002);
        rd(A_EN, rv);  check("R10 enable read zero", rv, 32'h0);
        rd(A_DIS, rv); check("R10 disable read zero", rv, 32'h0);
        rd(8'h00, rv); check("R10 unmapped read zero", rv, 32'h0);
        rd(8'h34, rv); check("R10 unmapped read zero", rv, 32'h0);
        rd(A_ST, rv);  check("R10 status kept", rv, 32'h0000_0002);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule